// File: doc/BRIEF.md
# Prioritized Three-Process Register Updater

This block holds two 16-bit counters, called the source count and the sink count. Three guarded processes change them. The grow process adds one to the source count. The move process takes one unit from the source count and gives it to the sink count in the same clock. The drain process removes one from the sink count. Each process has its own condition input.

A fixed priority settles conflicts: drain is highest, move is next and grow is lowest. No counter ever receives two updates in one clock. The move is never half applied. Grow and drain touch different counters, so they may act in the same clock whenever move is idle.

Each clock the condition inputs are sorted into one of five schedule states. SCH_IDLE means no process acts. SCH_GROW means grow alone. SCH_MOVE means move alone. SCH_DRAIN means drain alone. SCH_BOTH means grow and drain together. The transitions follow from the inputs as follows:
- cond_drain selects SCH_BOTH when cond_grow is also set, and SCH_DRAIN otherwise.
- Without cond_drain, cond_move selects SCH_MOVE.
- Without either of those, cond_grow selects SCH_GROW.
- Anything else selects SCH_IDLE.

The chosen schedule is applied at the next rising edge. Three strobes, registered at that same edge, report which processes took effect.

Top module: `prio_updater`

## Requirements
- R1: When rst_n is low at a rising edge (synchronous, active low), both counters become 0 and all three fired strobes become 0.
- R2: With only cond_grow high, the edge adds 1 to src_count, leaves snk_count unchanged and raises only grow_fired in the following cycle.
- R3: With only cond_drain high, the edge subtracts 1 from snk_count, leaves src_count unchanged and raises only drain_fired.
- R4: The move process fires exactly when cond_move is high and cond_drain is low. When it fires, src_count decreases by 1 and snk_count increases by 1 at the same edge, and only move_fired is raised.
- R5: When cond_drain is high, move does not fire even if cond_move is high. Drain fires instead.
- R6: When move fires, grow does not fire even if cond_grow is high, so src_count changes by exactly -1.
- R7: When cond_grow and cond_drain are high and move is not firing (cond_move low, or cond_move high but blocked by cond_drain), grow and drain both fire in the same edge: src_count +1, snk_count -1, and grow_fired and drain_fired are both high.
- R8: With all conditions low, both counters hold and all fired strobes are 0.
- R9: The counters are 16-bit unsigned and wrap. 0 minus 1 gives 16'hFFFF, and 16'hFFFF plus 1 gives 0.
- R10: Each fired strobe is high for exactly the cycle after an edge at which its process took effect, and is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cond_grow | input | 1 | Condition for the grow process (src +1) |
| cond_move | input | 1 | Condition for the move process (src -1, snk +1) |
| cond_drain | input | 1 | Condition for the drain process (snk -1) |
| src_count | output | 16 | Source counter value |
| snk_count | output | 16 | Sink counter value |
| grow_fired | output | 1 | Grow took effect at the last edge |
| move_fired | output | 1 | Move took effect at the last edge |
| drain_fired | output | 1 | Drain took effect at the last edge |

## Verification
The bench targets the overlap of conditions.

With all three conditions raised together, the drain-then-grow outcome is expected. A design that let move win would show src_count unchanged or snk_count unchanged. With cond_move and cond_grow raised together, a design that stacked grow on top of move would leave src_count unchanged instead of one lower. A design that only half applied the move would show one counter moving without the other.

Underflow through drain and through move from zero, followed by a grow past 16'hFFFF, exposes any counter that saturates or is wider than 16 bits. Idle cycles between bursts catch fired strobes that stick high.

// File: rtl/prio_updater_pkg.sv
package prio_updater_pkg;

    typedef enum logic [2:0] {
        SCH_IDLE  = 3'd0,
        SCH_GROW  = 3'd1,
        SCH_MOVE  = 3'd2,
        SCH_DRAIN = 3'd3,
        SCH_BOTH  = 3'd4
    } sched_e;

    typedef struct packed {
        logic grow;
        logic move;
        logic drain;
    } fire_t;

endpackage

// File: rtl/prio_sched.sv
module prio_sched
    import prio_updater_pkg::*;
(
    input  logic   cond_grow,
    input  logic   cond_move,
    input  logic   cond_drain,
    output sched_e sched,
    output fire_t  fire
);

    always_comb begin
        if (cond_drain)
            sched = cond_grow ? SCH_BOTH : SCH_DRAIN;
        else if (cond_move)
            sched = SCH_MOVE;
        else if (cond_grow)
            sched = SCH_GROW;
        else
            sched = SCH_IDLE;
    end

    always_comb begin
        fire = '0;
        unique case (sched)
            SCH_IDLE:  fire = '0;
            SCH_GROW:  fire.grow = 1'b1;
            SCH_MOVE:  fire.move = 1'b1;
            SCH_DRAIN: fire.drain = 1'b1;
            SCH_BOTH: begin
                fire.grow  = 1'b1;
                fire.drain = 1'b1;
            end
            default:   fire = '0;
        endcase
    end

    // R6: move and grow never granted together
    always_comb begin
        a_r6_move_excl: assert (!(fire.move && (fire.grow || fire.drain)));
    end

endmodule

// File: rtl/prio_counter.sv
module prio_counter #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             up,
    input  logic             down,
    output logic [WIDTH-1:0] value
);

    logic [WIDTH-1:0] value_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            value_q <= '0;
        else begin
            unique case ({up, down})
                2'b10:   value_q <= value_q + WIDTH'(1);
                2'b01:   value_q <= value_q - WIDTH'(1);
                default: value_q <= value_q;
            endcase
        end
    end

    assign value = value_q;

    // R4: a single writer per counter per cycle
    a_r4_single_writer: assert property (@(posedge clk) disable iff (!rst_n)
        !(up && down));

    // R9: step of exactly one, modulo 2**WIDTH
    a_r9_wrap_up: assert property (@(posedge clk) disable iff (!rst_n)
        up && !down |=> value == $past(value) + WIDTH'(1));

    a_r9_wrap_down: assert property (@(posedge clk) disable iff (!rst_n)
        down && !up |=> value == $past(value) - WIDTH'(1));

endmodule

// File: rtl/prio_updater.sv
module prio_updater
    import prio_updater_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cond_grow,
    input  logic             cond_move,
    input  logic             cond_drain,
    output logic [WIDTH-1:0] src_count,
    output logic [WIDTH-1:0] snk_count,
    output logic             grow_fired,
    output logic             move_fired,
    output logic             drain_fired
);

    sched_e sched;
    fire_t  fire;
    fire_t  fired_q;

    prio_sched u_sched (
        .cond_grow  (cond_grow),
        .cond_move  (cond_move),
        .cond_drain (cond_drain),
        .sched      (sched),
        .fire       (fire)
    );

    prio_counter #(.WIDTH(WIDTH)) u_src (
        .clk   (clk),
        .rst_n (rst_n),
        .up    (fire.grow),
        .down  (fire.move),
        .value (src_count)
    );

    prio_counter #(.WIDTH(WIDTH)) u_snk (
        .clk   (clk),
        .rst_n (rst_n),
        .up    (fire.move),
        .down  (fire.drain),
        .value (snk_count)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)
            fired_q <= '0;
        else
            fired_q <= fire;
    end

    assign grow_fired  = fired_q.grow;
    assign move_fired  = fired_q.move;
    assign drain_fired = fired_q.drain;

    // R4: both halves of a move land at the same edge
    a_r4_atomic_move: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && move_fired |->
            src_count == $past(src_count) - WIDTH'(1) &&
            snk_count == $past(snk_count) + WIDTH'(1));

    // R6: move excludes the other strobes
    a_r6_move_alone: assert property (@(posedge clk) disable iff (!rst_n)
        move_fired |-> !grow_fired && !drain_fired);

    // R5: drain wins over move
    a_r5_drain_over_move: assert property (@(posedge clk) disable iff (!rst_n)
        cond_drain |=> !move_fired && drain_fired);

    // R8: counters hold without a firing process
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !grow_fired && !move_fired && !drain_fired |->
            $stable(src_count) && $stable(snk_count));

    // R7: grow and drain together
    a_r7_pair: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && grow_fired && drain_fired |->
            src_count == $past(src_count) + WIDTH'(1) &&
            snk_count == $past(snk_count) - WIDTH'(1));

endmodule

// File: tb/prio_updater_test.sv
module prio_updater_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        c_grow = 1'b0;
    logic        c_move = 1'b0;
    logic        c_drain = 1'b0;
    logic [15:0] src;
    logic [15:0] snk;
    logic        f_grow;
    logic        f_move;
    logic        f_drain;

    int checks = 0;
    int failures = 0;
    logic [15:0] ex_src = 16'd0;
    logic [15:0] ex_snk = 16'd0;

    always #5 clk = ~clk;

    prio_updater uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cond_grow   (c_grow),
        .cond_move   (c_move),
        .cond_drain  (c_drain),
        .src_count   (src),
        .snk_count   (snk),
        .grow_fired  (f_grow),
        .move_fired  (f_move),
        .drain_fired (f_drain)
    );

    task automatic check16(string tag, string what, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic check3(string tag, logic [2:0] act, logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s fired{g,m,d} actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // Apply one cycle of conditions, predict from the requirements, check.
    task automatic step(string tag, logic g, logic m, logic d);
        logic eg, em, ed;
        @(negedge clk);
        c_grow = g; c_move = m; c_drain = d;
        ed = d;
        em = m && !d;
        eg = g && !em;
        if (ed) ex_snk = ex_snk - 16'd1;
        if (em) begin ex_src = ex_src - 16'd1; ex_snk = ex_snk + 16'd1; end
        if (eg) ex_src = ex_src + 16'd1;
        @(posedge clk);
        #1;
        check16(tag, "src", src, ex_src);
        check16(tag, "snk", snk, ex_snk);
        check3(tag, {f_grow, f_move, f_drain}, {eg, em, ed});
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0; c_grow = 1'b1; c_move = 1'b1; c_drain = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        ex_src = 16'd0; ex_snk = 16'd0;
        check16("R1", "src", src, 16'd0);
        check16("R1", "snk", snk, 16'd0);
        check3("R1", {f_grow, f_move, f_drain}, 3'b000);
        @(negedge clk);
        rst_n = 1'b1; c_grow = 1'b0; c_move = 1'b0;
    endtask

    task automatic t_grow();
        for (int i = 0; i < 4; i++) step("R2", 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_move();
        step("R4", 1'b0, 1'b1, 1'b0);
        step("R4", 1'b0, 1'b1, 1'b0);
    endtask

    task automatic t_drain();
        step("R3", 1'b0, 1'b0, 1'b1);
    endtask

    task automatic t_priority();
        step("R5", 1'b0, 1'b1, 1'b1);
        step("R6", 1'b1, 1'b1, 1'b0);
        step("R7", 1'b1, 1'b0, 1'b1);
        step("R7", 1'b1, 1'b1, 1'b1);
    endtask

    task automatic t_idle();
        step("R8", 1'b0, 1'b0, 1'b0);
        step("R10", 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_wrap();
        t_reset();
        step("R9", 1'b0, 1'b0, 1'b1);
        step("R9", 1'b0, 1'b1, 1'b0);
        step("R9", 1'b1, 1'b0, 1'b0);
        step("R10", 1'b1, 1'b0, 1'b0);
        step("R10", 1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        t_reset();
        t_grow();
        t_idle();
        t_move();
        t_drain();
        t_priority();
        t_idle();
        t_wrap();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule